// File: doc/BRIEF.md
# Crosspoint Selection Core with Staged Program Memory

This block is the digital heart of a 36-input crosspoint. It has 36 data outputs and one extra diagnostic output that feeds an activity monitor. Each output is a wide multiplexer whose select comes from an active selection register. The path from `in_data` to `out_data` and `diag_out` has no registers, so a bit on any input reaches every output routed to it in the same cycle. One input may fan out to any number of outputs.

Selections are programmed through a plain parallel control port and are not handshaked. A rising `load_pin` writes a 7-bit input code into the pending register of one output. While `cfg_pin` is high, every pending register is copied into the active registers. Holding `cfg_pin` high therefore makes each write take effect at once. Holding it low lets any number of writes be staged and then applied together. A 6-bit output address comes either from its own bus or, in shared-bus mode, from the low bits of `in_code` latched when `ale_pin` falls. `init_pin` restores the identity mapping. A code outside the input range switches an output off.

The strobes `load_pin`, `cfg_pin`, `ale_pin` and `init_pin` are asynchronous. Each passes through a two-flop synchronizer into `clk`. The address and code buses must stay stable from the strobe edge until four clock cycles after it. The data path has no valid/ready handshake: it is a bit-level path and never applies back-pressure.

Top module: `xpt_core`

## Requirements
- R1: Each output carries the value of the input whose index equals its active code (0 to 35), with no register on the path; several outputs may hold the same code and then carry the same input.
- R2: A rising edge on `load_pin` writes `in_code` (7 bits) into the pending register of the addressed output only; an address of 36 to 63 with `diag_sel` low writes nothing.
- R3: While `cfg_pin` is low, the active codes do not change, however many writes occur. While `cfg_pin` is high, all pending codes are copied to the active codes. After `cfg_pin` falls, the active codes hold.
- R4: With `cfg_pin` held high, a write reaches its output within five clock cycles of the `load_pin` rise.
- R5: Reset, and `init_pin` held high, set every pending and active code to the identity mapping: output n takes input n, and the diagnostic output takes input 0. Any disabled output is re-enabled.
- R6: An output whose active code is 36 to 127 (127 is the reserved switch-off code) drives 0. Writing a valid code later restores routing.
- R7: With `mux_mode` high, the falling edge of `ale_pin` latches `in_code[5:0]` as the output address. Later writes use that address while `out_addr` is ignored.
- R8: When `diag_sel` is high and bit 5 of the effective output address is 1, the write targets the diagnostic output, whatever the other address bits are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_data | input | 36 | Data inputs |
| out_data | output | 36 | Routed data outputs |
| diag_out | output | 1 | Diagnostic output toward the activity monitor |
| load_pin | input | 1 | Write strobe, acts on its rising edge |
| cfg_pin | input | 1 | Apply level: pending codes are copied to the active codes while high |
| ale_pin | input | 1 | Address latch, acts on its falling edge in shared-bus mode |
| init_pin | input | 1 | Identity-mapping level |
| mux_mode | input | 1 | 1 selects the shared address/code bus |
| diag_sel | input | 1 | Enables addressing of the diagnostic output |
| out_addr | input | 6 | Output address in separate-bus mode |
| in_code | input | 7 | Input code, or the output address during the ALE phase |

## Verification
The hardest case to reach is the window in which pending and active codes differ. The bench holds `cfg_pin` low while it writes a full new map containing duplicate codes to all 37 outputs. It then runs a walking-one sweep across all 36 inputs to show that the old identity map is still routed. After one apply pulse, the same sweep must match the new map. The shared-bus latch, the switch-off codes and the diagnostic address are each reached by short scripted sequences. Each sequence is followed by the same input sweep.

// File: rtl/xpt_pkg.sv
`timescale 1ns/1ps
package xpt_pkg;
  localparam int SYNC_DEPTH = 2;

  // Source index for the identity mapping; extra outputs fall back to input 0.
  function automatic int unsigned straight_src(input int unsigned out_idx,
                                               input int unsigned n_in);
    return (out_idx < n_in) ? out_idx : 0;
  endfunction
endpackage

// File: rtl/xpt_sync.sv
`timescale 1ns/1ps
module xpt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic lvl_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], async_i};
  end

  assign lvl_o = chain_q[STAGES-1];
endmodule

// File: rtl/xpt_addr_dec.sv
`timescale 1ns/1ps
module xpt_addr_dec #(
  parameter int N_DATA = 36,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mux_mode,
  input  logic              diag_sel,
  input  logic              ale_fall,
  input  logic              load_rise,
  input  logic [ADDR_W-1:0] out_addr,
  input  logic [ADDR_W-1:0] bus_low,
  output logic [N_DATA:0]   we
);
  localparam int DIAG_BIT = ADDR_W - 1;

  logic [ADDR_W-1:0] lat_q;
  logic [ADDR_W-1:0] eff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        lat_q <= '0;
    else if (ale_fall) lat_q <= bus_low;
  end

  assign eff = mux_mode ? lat_q : out_addr;

  always_comb begin
    we = '0;
    if (load_rise) begin
      if (diag_sel && eff[DIAG_BIT]) begin
        we[N_DATA] = 1'b1;
      end else begin
        for (int i = 0; i < N_DATA; i++) begin
          if (eff == ADDR_W'(i)) we[i] = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/xpt_pmem.sv
`timescale 1ns/1ps
module xpt_pmem #(
  parameter int N_OUT  = 37,
  parameter int N_IN   = 36,
  parameter int CODE_W = 7
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_OUT-1:0]        we,
  input  logic [CODE_W-1:0]       wr_code,
  input  logic                    cfg_lvl,
  input  logic                    init_lvl,
  output logic [N_OUT*CODE_W-1:0] shadow_flat,
  output logic [N_OUT*CODE_W-1:0] main_flat
);
  for (genvar g = 0; g < N_OUT; g++) begin : g_slot
    localparam logic [CODE_W-1:0] IDENT = CODE_W'(xpt_pkg::straight_src(g, N_IN));
    logic [CODE_W-1:0] sh_q, mn_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        sh_q <= IDENT;
      else if (init_lvl) sh_q <= IDENT;
      else if (we[g])    sh_q <= wr_code;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        mn_q <= IDENT;
      else if (init_lvl) mn_q <= IDENT;
      else if (cfg_lvl)  mn_q <= sh_q;
    end

    assign shadow_flat[g*CODE_W +: CODE_W] = sh_q;
    assign main_flat[g*CODE_W +: CODE_W]   = mn_q;
  end
endmodule

// File: rtl/xpt_mux_col.sv
`timescale 1ns/1ps
module xpt_mux_col #(
  parameter int N_IN   = 36,
  parameter int CODE_W = 7
) (
  input  logic [N_IN-1:0]   in_data,
  input  logic [CODE_W-1:0] sel,
  output logic              y
);
  always_comb begin
    y = 1'b0;
    for (int j = 0; j < N_IN; j++) begin
      if (sel == CODE_W'(j)) y = in_data[j];
    end
  end
endmodule

// File: rtl/xpt_core.sv
`timescale 1ns/1ps
module xpt_core #(
  parameter int N_IN   = 36,
  parameter int N_DATA = 36,
  parameter int ADDR_W = 6,
  parameter int CODE_W = 7,
  parameter int SYNC_N = xpt_pkg::SYNC_DEPTH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_IN-1:0]   in_data,
  output logic [N_DATA-1:0] out_data,
  output logic              diag_out,
  input  logic              load_pin,
  input  logic              cfg_pin,
  input  logic              ale_pin,
  input  logic              init_pin,
  input  logic              mux_mode,
  input  logic              diag_sel,
  input  logic [ADDR_W-1:0] out_addr,
  input  logic [CODE_W-1:0] in_code
);
  localparam int N_OUT = N_DATA + 1;

  logic load_lvl, cfg_lvl, ale_lvl, init_lvl;
  logic load_q, ale_q;
  logic load_rise, ale_fall;
  logic [N_OUT-1:0]        we;
  logic [N_OUT*CODE_W-1:0] shadow_flat, main_flat;
  logic [N_OUT-1:0]        cols;

  xpt_sync #(.STAGES(SYNC_N)) u_s_load (.clk(clk), .rst_n(rst_n), .async_i(load_pin), .lvl_o(load_lvl));
  xpt_sync #(.STAGES(SYNC_N)) u_s_cfg  (.clk(clk), .rst_n(rst_n), .async_i(cfg_pin),  .lvl_o(cfg_lvl));
  xpt_sync #(.STAGES(SYNC_N)) u_s_ale  (.clk(clk), .rst_n(rst_n), .async_i(ale_pin),  .lvl_o(ale_lvl));
  xpt_sync #(.STAGES(SYNC_N)) u_s_init (.clk(clk), .rst_n(rst_n), .async_i(init_pin), .lvl_o(init_lvl));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q <= 1'b0;
      ale_q  <= 1'b0;
    end else begin
      load_q <= load_lvl;
      ale_q  <= ale_lvl;
    end
  end

  assign load_rise = load_lvl & ~load_q;
  assign ale_fall  = ~ale_lvl & ale_q;

  xpt_addr_dec #(.N_DATA(N_DATA), .ADDR_W(ADDR_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .mux_mode(mux_mode), .diag_sel(diag_sel),
    .ale_fall(ale_fall), .load_rise(load_rise), .out_addr(out_addr),
    .bus_low(in_code[ADDR_W-1:0]), .we(we));

  xpt_pmem #(.N_OUT(N_OUT), .N_IN(N_IN), .CODE_W(CODE_W)) u_mem (
    .clk(clk), .rst_n(rst_n), .we(we), .wr_code(in_code),
    .cfg_lvl(cfg_lvl), .init_lvl(init_lvl),
    .shadow_flat(shadow_flat), .main_flat(main_flat));

  for (genvar g = 0; g < N_OUT; g++) begin : g_col
    xpt_mux_col #(.N_IN(N_IN), .CODE_W(CODE_W)) u_col (
      .in_data(in_data), .sel(main_flat[g*CODE_W +: CODE_W]), .y(cols[g]));
  end

  assign out_data = cols[N_DATA-1:0];
  assign diag_out = cols[N_DATA];
endmodule

// File: rtl/xpt_core_chk.sv
`timescale 1ns/1ps
module xpt_core_chk #(
  parameter int N_IN   = 36,
  parameter int N_OUT  = 37,
  parameter int CODE_W = 7
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    cfg_lvl,
  input logic                    init_lvl,
  input logic                    load_rise,
  input logic [N_OUT-1:0]        we,
  input logic [N_OUT*CODE_W-1:0] shadow_flat,
  input logic [N_OUT*CODE_W-1:0] main_flat,
  input logic [N_OUT-1:0]        cols
);
  function automatic logic [N_OUT*CODE_W-1:0] ident_map();
    logic [N_OUT*CODE_W-1:0] r;
    for (int i = 0; i < N_OUT; i++)
      r[i*CODE_W +: CODE_W] = CODE_W'(xpt_pkg::straight_src(i, N_IN));
    return r;
  endfunction

  localparam logic [N_OUT*CODE_W-1:0] IDENT_FLAT = ident_map();

  assert_main_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_lvl && !init_lvl) |=> $stable(main_flat));

  assert_main_copy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_lvl && !init_lvl) |=> (main_flat == $past(shadow_flat)));

  assert_init_ident_R5: assert property (@(posedge clk) disable iff (!rst_n)
    init_lvl |=> (main_flat == IDENT_FLAT && shadow_flat == IDENT_FLAT));

  assert_single_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(we));

  assert_write_needs_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|we) |-> load_rise);

  for (genvar g = 0; g < N_OUT; g++) begin : g_off
    always_comb begin
      if (rst_n && (main_flat[g*CODE_W +: CODE_W] >= CODE_W'(N_IN)))
        assert_disabled_zero_R6: assert (cols[g] == 1'b0);
    end
  end
endmodule

bind xpt_core xpt_core_chk #(.N_IN(N_IN), .N_OUT(N_OUT), .CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_lvl(cfg_lvl), .init_lvl(init_lvl),
  .load_rise(load_rise), .we(we), .shadow_flat(shadow_flat),
  .main_flat(main_flat), .cols(cols));

// File: tb/sim_xpt_core.sv
`timescale 1ns/1ps
module sim_xpt_core;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [35:0] in_data = '0;
  logic [35:0] out_data;
  logic        diag_out;
  logic        load_pin = 0, cfg_pin = 0, ale_pin = 0, init_pin = 0;
  logic        mux_mode = 0, diag_sel = 0;
  logic [5:0]  out_addr = '0;
  logic [6:0]  in_code = '0;

  int checks = 0;
  int errors = 0;
  int sh_m[37];
  int mn_m[37];
  bit cfg_hold = 0;

  always #2.5 clk = ~clk;

  xpt_core u0 (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .out_data(out_data),
    .diag_out(diag_out), .load_pin(load_pin), .cfg_pin(cfg_pin),
    .ale_pin(ale_pin), .init_pin(init_pin), .mux_mode(mux_mode),
    .diag_sel(diag_sel), .out_addr(out_addr), .in_code(in_code));

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic model_ident();
    for (int o = 0; o < 37; o++) begin
      sh_m[o] = (o < 36) ? o : 0;
      mn_m[o] = sh_m[o];
    end
  endtask

  // Write: addr is the bus value, code the 7-bit input code
  task automatic prog(input int addr, input int code, input bit use_mux, input bit dsel);
    int tgt;
    @(negedge clk);
    mux_mode = use_mux;
    diag_sel = dsel;
    if (use_mux) begin
      in_code = 7'(addr);
      out_addr = 6'h15;           // must be ignored in shared-bus mode
      ale_pin = 1; wait_n(4);
      ale_pin = 0; wait_n(4);
      in_code = 7'(code);
    end else begin
      out_addr = 6'(addr);
      in_code  = 7'(code);
    end
    wait_n(1);
    load_pin = 1; wait_n(4);
    load_pin = 0; wait_n(4);
    if (dsel && addr[5]) tgt = 36;
    else if (addr < 36)  tgt = addr;
    else                 tgt = -1;
    if (tgt >= 0) sh_m[tgt] = code;
    if (cfg_hold) for (int o = 0; o < 37; o++) mn_m[o] = sh_m[o];
  endtask

  task automatic pulse_cfg();
    @(negedge clk); cfg_pin = 1; wait_n(4);
    cfg_pin = 0; wait_n(4);
    for (int o = 0; o < 37; o++) mn_m[o] = sh_m[o];
  endtask

  task automatic pulse_init();
    @(negedge clk); init_pin = 1; wait_n(4);
    init_pin = 0; wait_n(4);
    model_ident();
  endtask

  function automatic logic route(input logic [35:0] pat, input int code);
    return (code < 36) ? pat[code] : 1'b0;
  endfunction

  // Sweep: walking one over every input, then all ones, then a mixed word
  task automatic check_all(input string tag);
    logic [35:0] pat;
    logic [35:0] exp_d;
    logic        exp_g;
    for (int p = 0; p < 38; p++) begin
      if (p < 36)       pat = 36'd1 << p;
      else if (p == 36) pat = '1;
      else              pat = 36'h5A3C96E1B;
      @(negedge clk);
      in_data = pat;
      #1;
      for (int o = 0; o < 36; o++) exp_d[o] = route(pat, mn_m[o]);
      exp_g = route(pat, mn_m[36]);
      checks++;
      if (out_data !== exp_d || diag_out !== exp_g) begin
        errors++;
        $display("FAIL %s pattern %h: out=%h diag=%b expected out=%h diag=%b",
                 tag, pat, out_data, diag_out, exp_d, exp_g);
      end
    end
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    model_ident();
    wait_n(3);
    rst_n = 1;
    wait_n(3);
    check_all("R5 reset identity");

    // Stage a full map with duplicates while apply is low (R2, R3)
    for (int o = 0; o < 36; o++) prog(o, (o * 5 + 1) % 12, 0, 0);
    prog(32, 7, 0, 1);   // R8: diag target via bit 5
    check_all("R3 hold before apply");
    pulse_cfg();
    check_all("R1 multicast after apply");
    check_all("R8 diag routed");

    // R2: out of range address with diag_sel low is ignored
    prog(40, 20, 0, 0);
    pulse_cfg();
    check_all("R2 ignored address");

    // Apply held high (R4)
    @(negedge clk); cfg_pin = 1; cfg_hold = 1; wait_n(4);
    prog(10, 33, 0, 0);
    check_all("R4 immediate apply");

    // Switch-off codes (R6)
    prog(3, 127, 0, 0);
    prog(4, 40, 0, 0);
    prog(5, 36, 0, 0);
    prog(63, 127, 0, 1);
    check_all("R6 disabled outputs");
    prog(3, 9, 0, 0);
    prog(63, 35, 0, 1);
    check_all("R6 re-enabled");

    // Shared bus (R7)
    prog(17, 2, 1, 0);
    prog(35, 0, 1, 0);
    prog(33, 11, 1, 1);  // R8 through latched address
    check_all("R7 shared bus");
    @(negedge clk); cfg_pin = 0; cfg_hold = 0; wait_n(4);

    // Init restores identity and clears disables (R5)
    prog(6, 127, 0, 0);
    pulse_cfg();
    check_all("R6 before init");
    pulse_init();
    check_all("R5 init identity");
    pulse_cfg();
    check_all("R5 init pending identity");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule